// File: doc/BRIEF.md
# Serial Audio Link Input Frame Receiver

This block sits on the controller side of a serial audio link and turns the codec's incoming serial stream into parallel frame data. It runs on the link's bit clock. It watches the frame-sync signal that the controller itself drives, and uses it to find where each frame begins. The codec launches every bit on a rising clock edge. The receiver captures each bit on the following falling edge, so all of the receiver's state changes on falling edges.

Each 256-bit frame holds a 16-bit tag slot followed by twelve 20-bit data slots, and every slot is sent MSB first. The tag carries the codec-ready flag, then one valid flag per data slot, then three bits that the receiver does not use. When the last bit of slot 12 has been captured, the receiver publishes the ready flag, the twelve valid flags and the twelve slot words together, and raises a one-cycle strobe. These outputs then hold until the next frame completes.

A watchdog starts at the first frame sync seen after reset. If no completed frame has reported the codec as ready within a fixed number of bit clocks, it latches a timeout flag. The default is 4916 clocks, which is about 400 µs at 12.288 MHz.

Top module: `aclink_rx_frame`

## Requirements
- R1: While reset is asserted and after it is released, all outputs are 0 until the first frame completes.
- R2: On a falling clock edge where frame sync is sampled high after having been sampled low, a new frame starts. The next 256 falling edges capture frame bits 0 to 255. Bits 0 to 15 form the tag, and bits 16 to 255 form slots 1 to 12 of 20 bits each, each MSB first. Frames may follow each other with no gap.
- R3: The word of slot n (1 to 12) appears on `slot_data_o[(n-1)*20 +: 20]`. The first captured bit of the slot lands in bit 19 of that word.
- R4: `codec_ready_o` equals frame bit 0, which is tag bit 15, of the last completed frame.
- R5: `slot_valid_o[n-1]` equals frame bit n, which is tag bit 15-n, for slot n of 1 to 12. Tag bits 2 to 0 (frame bits 13 to 15) have no effect on any output.
- R6: `frame_done_o` is high for exactly one clock after the falling edge that captures frame bit 255. Consecutive pulses are at least 256 clocks apart.
- R7: Between `frame_done_o` pulses, ready, valid and slot outputs hold their values.
- R8: A frame sync start seen before bit 255 is captured abandons the partial frame. That partial frame produces no pulse and changes no output, and capture restarts at bit 0.
- R9: If no frame with ready = 1 has completed, `ready_timeout_o` rises on the TIMEOUT_CYC-th falling edge after the first frame-sync start following reset. Once set, it stays at 1 until reset.
- R10: If a frame with ready = 1 completes before that edge, `ready_timeout_o` never rises before the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| link_clk | input | 1 | Link bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync_i | input | 1 | Frame sync as driven by the controller |
| ser_in_i | input | 1 | Serial data from the codec |
| frame_done_o | output | 1 | One-clock strobe when a frame completes |
| codec_ready_o | output | 1 | Ready flag of the last completed frame |
| slot_valid_o | output | 12 | Valid flag per data slot; bit n-1 is slot n |
| slot_data_o | output | 240 | Slot words; slot n at bits (n-1)*20 upward |
| ready_timeout_o | output | 1 | Latched error: codec never reported ready in time |

## Verification
The bench drives frame sync and serial data 1 ns after each rising edge, as a codec would. A bit driven on a rising edge is captured on the falling edge that follows. The bit launched one rising edge after a frame's last bit-255 drive, at the first rising edge of a flush cycle or of the next frame, is captured on the falling edge after it. The completed frame's outputs and strobe change on that falling edge, so the bench samples them 1 ns later and checks that the strobe has dropped one falling edge after that. The timeout flag is compared 2 ns after every falling edge while its phase runs. The expected value is 1 from the TIMEOUT_CYC-th falling edge after the edge that detected the first sync, so the rise is pinned to the exact edge.

// File: rtl/aclink_rx_frame.sv
`timescale 1ns/1ps
module aclink_rx_frame #(
  parameter int TAG_W       = 16,
  parameter int SLOTS       = 12,
  parameter int SLOT_W      = 20,
  parameter int TIMEOUT_CYC = 4916
) (
  input  logic                      link_clk,
  input  logic                      rst_n,
  input  logic                      frame_sync_i,
  input  logic                      ser_in_i,
  output logic                      frame_done_o,
  output logic                      codec_ready_o,
  output logic [SLOTS-1:0]          slot_valid_o,
  output logic [SLOTS*SLOT_W-1:0]   slot_data_o,
  output logic                      ready_timeout_o
);
  localparam int FRAME_BITS = TAG_W + SLOTS * SLOT_W;
  localparam int PW = $clog2(FRAME_BITS);
  localparam int BW = $clog2(SLOT_W);
  localparam int IW = $clog2(SLOTS + 1);
  localparam int WW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [PW-1:0] POS_LAST = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] TAG_LAST = PW'(TAG_W - 1);
  localparam logic [PW-1:0] DATA_FIRST = PW'(TAG_W);
  localparam logic [BW-1:0] BIT_LAST = BW'(SLOT_W - 1);
  localparam logic [WW-1:0] WD_LAST = WW'(TIMEOUT_CYC - 1);

  logic                          sync_q, active;
  logic [PW-1:0]                 pos;
  logic [BW-1:0]                 sbit;
  logic [IW-1:0]                 sidx;
  logic [SLOT_W-1:0]             sh;
  logic [TAG_W-1:0]              tag_st;
  logic [SLOTS-1:0][SLOT_W-1:0]  slot_st, slot_q;
  logic                          started, ready_seen;
  logic [WW-1:0]                 wd;

  wire              sync_rise = frame_sync_i & ~sync_q;
  wire [SLOT_W-1:0] word      = {sh[SLOT_W-2:0], ser_in_i};
  wire              last_bit  = active && (pos == POS_LAST);
  wire              rdy_now   = ready_seen | (last_bit & tag_st[TAG_W-1]);

  assign slot_data_o = slot_q;

  always_ff @(negedge link_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0; active <= 1'b0; pos <= '0; sbit <= '0; sidx <= '0;
      sh <= '0; tag_st <= '0; slot_st <= '0; slot_q <= '0;
      frame_done_o <= 1'b0; codec_ready_o <= 1'b0; slot_valid_o <= '0;
    end else begin
      sync_q       <= frame_sync_i;
      frame_done_o <= 1'b0;
      if (active) begin
        sh <= word;
        if (pos == TAG_LAST) tag_st <= word[TAG_W-1:0];
        if (pos >= DATA_FIRST) begin
          if (sbit == BIT_LAST) begin
            slot_st[sidx] <= word;
            sbit <= '0;
            sidx <= sidx + 1'b1;
          end else begin
            sbit <= sbit + 1'b1;
          end
        end
        if (pos == POS_LAST) begin
          slot_q            <= slot_st;
          slot_q[SLOTS-1]   <= word;
          codec_ready_o     <= tag_st[TAG_W-1];
          for (int k = 0; k < SLOTS; k++) slot_valid_o[k] <= tag_st[TAG_W-2-k];
          frame_done_o      <= 1'b1;
        end
      end
      if (sync_rise) begin
        pos <= '0; active <= 1'b1; sbit <= '0; sidx <= '0;
      end else if (active) begin
        pos <= pos + 1'b1;
        if (pos == POS_LAST) active <= 1'b0;
      end
    end
  end

  always_ff @(negedge link_clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0; ready_seen <= 1'b0; wd <= '0; ready_timeout_o <= 1'b0;
    end else begin
      ready_seen <= rdy_now;
      if (sync_rise && !started) begin
        started <= 1'b1;
        wd      <= '0;
      end else if (started && !rdy_now && !ready_timeout_o) begin
        if (wd == WD_LAST) ready_timeout_o <= 1'b1;
        else wd <= wd + 1'b1;
      end
    end
  end
endmodule

module aclink_rx_frame_chk #(
  parameter int SLOTS  = 12,
  parameter int SLOT_W = 20
) (
  input logic                    link_clk,
  input logic                    rst_n,
  input logic                    frame_done_o,
  input logic                    codec_ready_o,
  input logic [SLOTS-1:0]        slot_valid_o,
  input logic [SLOTS*SLOT_W-1:0] slot_data_o,
  input logic                    ready_timeout_o
);
  logic [9:0] gap;
  always_ff @(negedge link_clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (frame_done_o) gap <= '0;
    else if (gap != 10'h3ff) gap <= gap + 1'b1;
  end

  p_done_single_r6: assert property (@(negedge link_clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
  p_done_gap_r6: assert property (@(negedge link_clk) disable iff (!rst_n)
    frame_done_o |-> gap >= 10'd255);
  p_hold_data_r7: assert property (@(negedge link_clk) disable iff (!rst_n)
    !frame_done_o |-> $stable(slot_data_o));
  p_hold_tag_r7: assert property (@(negedge link_clk) disable iff (!rst_n)
    !frame_done_o |-> ($stable(slot_valid_o) && $stable(codec_ready_o)));
  p_timeout_latch_r9: assert property (@(negedge link_clk) disable iff (!rst_n)
    ready_timeout_o |=> ready_timeout_o);
  p_timeout_no_ready_r10: assert property (@(negedge link_clk) disable iff (!rst_n)
    $rose(ready_timeout_o) |-> !codec_ready_o);
endmodule

bind aclink_rx_frame aclink_rx_frame_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .link_clk(link_clk), .rst_n(rst_n), .frame_done_o(frame_done_o),
  .codec_ready_o(codec_ready_o), .slot_valid_o(slot_valid_o),
  .slot_data_o(slot_data_o), .ready_timeout_o(ready_timeout_o));

// File: tb/sim_aclink_rx_frame.sv
`timescale 1ns/1ps
module sim_aclink_rx_frame;
  localparam int TO = 4916;
  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, sd = 1'b0;
  logic done, rdy, tmo;
  logic [11:0] valid;
  logic [239:0] data;
  int vectors = 0, errors = 0, done_cnt = 0, e = 0;
  bit armed = 0, det = 0, mon_en = 0;
  logic carry = 1'b0;

  always #5 clk = ~clk;

  aclink_rx_frame u0 (
    .link_clk(clk), .rst_n(rst_n), .frame_sync_i(fsync), .ser_in_i(sd),
    .frame_done_o(done), .codec_ready_o(rdy), .slot_valid_o(valid),
    .slot_data_o(data), .ready_timeout_o(tmo));

  task automatic chk(string req, logic [255:0] act, logic [255:0] expv);
    vectors++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [19:0] dval(int f, int k);
    if (f == 1) return 20'hfffff;
    if (f == 2) return 20'h0;
    return 20'((f * 32'h2b3d + k * 32'h1c9 + 32'h5a5a5) & 32'hfffff);
  endfunction

  function automatic logic [11:0] vval(int f);
    if (f == 1) return 12'hfff;
    if (f == 2) return 12'h000;
    return 12'((f * 32'h5a7 + 32'h3c1) & 32'hfff);
  endfunction

  function automatic logic [255:0] mk(logic r, logic [11:0] vv, logic [2:0] id, int f);
    logic [255:0] v = '0;
    v[255] = r;
    v[254:243] = vv;
    v[242:240] = id;
    for (int k = 0; k < 12; k++) v[239-20*k -: 20] = dval(f, k);
    return v;
  endfunction

  task automatic run_frame(logic [255:0] v);
    for (int t = 0; t < 256; t++) begin
      @(posedge clk); #1;
      fsync = (t < 16);
      sd = (t == 0) ? carry : v[256-t];
      armed = 1;
    end
    carry = v[0];
  endtask

  task automatic run_part(logic [255:0] v, int n);
    for (int t = 0; t < n; t++) begin
      @(posedge clk); #1;
      fsync = (t < 16);
      sd = (t == 0) ? carry : v[256-t];
    end
    carry = v[256-n];
  endtask

  task automatic check_out(logic [255:0] v, string tag);
    logic [11:0] ev;
    for (int k = 0; k < 12; k++) ev[k] = v[254-k];
    chk({"R4 ready ", tag}, 256'(rdy), 256'(v[255]));
    chk({"R5 valid ", tag}, 256'(valid), 256'(ev));
    for (int k = 0; k < 12; k++)
      chk({"R3 slot ", tag}, 256'(data[k*20 +: 20]), 256'(v[239-20*k -: 20]));
  endtask

  task automatic flush_check(logic [255:0] v, string tag);
    @(posedge clk); #1;
    fsync = 1'b0;
    sd = carry;
    @(negedge clk); #1;
    chk({"R6 strobe high ", tag}, 256'(done), 256'(1));
    check_out(v, tag);
    @(negedge clk); #1;
    chk({"R6 strobe low ", tag}, 256'(done), 256'(0));
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; armed = 0; det = 0; fsync = 1'b0; sd = 1'b0; carry = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 done", 256'(done), 256'(0));
    chk("R1 ready", 256'(rdy), 256'(0));
    chk("R1 valid", 256'(valid), 256'(0));
    chk("R1 data", 256'(data), 256'(0));
    chk("R1 timeout", 256'(tmo), 256'(0));
    rst_n = 1'b1;
  endtask

  always @(posedge clk) if (done) done_cnt++;

  always @(negedge clk) begin
    #2;
    if (mon_en) begin
      if (det) e++;
      else if (armed) begin det = 1; e = 0; end
      chk("R9 timeout edge", 256'(tmo), 256'(det && e >= TO));
    end
  end

  initial begin : watchdog
    #1_500_000;
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [255:0] v, va, vb;
    int c0;
    do_reset();

    // R9: never ready, timeout rises on the exact edge and stays latched
    mon_en = 1;
    for (int f = 0; f < 20; f++) begin
      v = mk(1'b0, vval(f), 3'(f), f);
      run_frame(v);
    end
    flush_check(v, "no-ready");
    mon_en = 0;
    chk("R9 timeout set", 256'(tmo), 256'(1));
    v = mk(1'b1, 12'h5a5, 3'd1, 7);
    run_frame(v);
    flush_check(v, "late ready");
    chk("R9 timeout latched", 256'(tmo), 256'(1));

    do_reset();
    // R2 R3 R4 R5 sweep; R10 ready in time
    for (int f = 0; f < 20; f++) begin
      v = mk(f != 3, vval(f), 3'(f), f);
      run_frame(v);
      flush_check(v, "sweep");
      if (f == 5) begin
        c0 = done_cnt;
        repeat (40) @(posedge clk);
        #1;
        check_out(v, "R7 hold");
        chk("R7 no extra strobe", 256'(done_cnt), 256'(c0));
      end
      repeat (8) @(posedge clk);
    end
    chk("R10 no timeout", 256'(tmo), 256'(0));

    // R5: tag bits 2..0 do not affect outputs
    v = mk(1'b1, 12'h3c3, 3'd7, 9);
    run_frame(v);
    flush_check(v, "R5 id7");
    v = mk(1'b1, 12'h3c3, 3'd0, 9);
    run_frame(v);
    flush_check(v, "R5 id0");

    // R8: early sync abandons a partial frame
    c0 = done_cnt;
    run_part(mk(1'b0, 12'hfff, 3'd0, 1), 120);
    v = mk(1'b1, 12'h0f0, 3'd5, 11);
    run_frame(v);
    flush_check(v, "R8 restart");
    chk("R8 one strobe", 256'(done_cnt), 256'(c0 + 1));

    // R2: back-to-back frames
    c0 = done_cnt;
    va = mk(1'b1, 12'h812, 3'd2, 13);
    vb = mk(1'b0, 12'h7ed, 3'd4, 14);
    run_frame(va);
    run_frame(vb);
    flush_check(vb, "R2 back-to-back");
    chk("R2 two strobes", 256'(done_cnt), 256'(c0 + 2));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule